// File: doc/BRIEF.md
# Compressed-Target Branch Target Buffer

This block predicts where a taken branch will go, given the address it is fetched from. It is a set-associative table: each set holds several "near" ways plus a single "far" way. A near way keeps only the low part of the destination (bits below `LOW_W`) and rebuilds the upper part from the fetch address at lookup time, so most entries cost a fraction of a full address. Branches whose destination leaves the aligned window of the branch itself are placed in the far way, which keeps the whole destination.

Lookup is combinational: the fetch address selects a set, every way in that set is compared against its tag at once, and the hit flag and predicted destination appear in the same cycle. Training goes through a single update port that carries the resolved branch address, its destination and whether it was taken. The update is written on the next rising clock edge and is visible to lookups from then on. Near entries are replaced in a per-set round-robin order. Near-to-far and far-to-near moves, and not-taken outcomes, remove stale entries so that a branch never matches more than one entry.

Top module: `ctb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an update has been written.
- R2: A lookup that matches no valid entry drives `lkHit` low and `lkTarget` to all zeros.
- R3: A taken update whose destination bits at `LOW_W` (16) and above equal those bits of the branch address is stored in a near way. A later lookup of that address hits and returns `{lkPc[31:16], stored low 16 bits}`, which equals the trained destination.
- R4: A taken update whose destination differs from the branch address anywhere in bits 31..16 is far. It goes only into the set's far way and is returned unchanged on a hit. A difference in bit 16 alone is far, and a difference in bit 15 alone is near.
- R5: With the default parameters the set index is `pc[5:2]` and the tag is `pc[31:6]`. Bits 1..0 of the lookup address are ignored. Another address in the same set with a different tag misses.
- R6: A taken near update for an address that already has a near entry rewrites that entry in place. The other ways and the round-robin pointer are left unchanged.
- R7: A near update that has no existing entry takes the way named by the set's round-robin pointer, which starts at way 0 after reset and advances by one, wrapping, on each such allocation.
- R8: A not-taken update removes any entry of that address from its set, leaving the other entries in place.
- R9: When an address moves between the near and far classes, its old entry is removed so that the address matches exactly one entry. A far entry and the set's near entries coexist, giving `NEAR_WAYS`+1 live entries per set.
- R10: Each set has one far way, so a second far branch in the same set replaces the first.
- R11: When `updValid` is low the table is not modified, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all valid bits |
| lkPc | input | ADDR_W | Fetch address to look up |
| lkHit | output | 1 | A valid entry matches `lkPc` |
| lkTarget | output | ADDR_W | Predicted destination, zero on a miss |
| updValid | input | 1 | Update strobe |
| updPc | input | ADDR_W | Address of the resolved branch |
| updTarget | input | ADDR_W | Resolved destination |
| updTaken | input | 1 | Branch was taken (1) or not taken (0) |

## Verification
The bench trains the near ways and the far way of every set, then checks hits, misses, alias tags and ignored alignment bits. A design that decoded index or tag bits wrongly would return hits in the wrong set or aliases. The near/far split is probed exactly at bit 16 against bit 15. A design with an off-by-one class boundary would put a bit-16 branch in a near way, where it would survive a later far allocation that should have evicted it. The bench tracks the round-robin order across allocations and in-place rewrites, and exercises class moves and not-taken removals. A design that advanced the pointer on a rewrite would evict the wrong entry later. A design that left stale entries behind would return an old destination or fail to free a way.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  // Width of the way selector carried in the strobe struct (up to 8 near ways).
  localparam int unsigned WAY_IDX_W = 3;

  typedef struct packed {
    logic                 wrNear;    // write near way nearWay of the update set
    logic [WAY_IDX_W-1:0] nearWay;
    logic                 wrFar;     // write far way of the update set
    logic                 killNear;  // clear near ways matching the update tag
    logic                 killFar;   // clear far way if it matches the update tag
  } ctbStrobe_t;
endpackage

// File: rtl/ctb_datapath.sv
module ctb_datapath
  import ctb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SETS      = 16,
  parameter int unsigned NEAR_WAYS = 2,
  parameter int unsigned LOW_W     = 16,
  parameter int unsigned ALIGN_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    lkPc,
  output logic                 lkHit,
  output logic [ADDR_W-1:0]    lkTarget,
  input  logic [ADDR_W-1:0]    updPc,
  input  logic [ADDR_W-1:0]    updTarget,
  input  ctbStrobe_t           strobe,
  output logic                 updNearHit,
  output logic [WAY_IDX_W-1:0] updNearWay,
  output logic                 updFarHit
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - ALIGN_W - IDX_W;

  logic [NEAR_WAYS-1:0] nearValid [SETS];
  logic [TAG_W-1:0]     nearTag   [SETS][NEAR_WAYS];
  logic [LOW_W-1:0]     nearLow   [SETS][NEAR_WAYS];
  logic [SETS-1:0]      farValid;
  logic [TAG_W-1:0]     farTag    [SETS];
  logic [ADDR_W-1:0]    farTgt    [SETS];

  logic [IDX_W-1:0] lkSet, updSet;
  logic [TAG_W-1:0] lkTag, updTag;
  logic [NEAR_WAYS-1:0] lkNearMatch, updNearMatch;
  logic lkFarMatch;
  logic [LOW_W-1:0] nearSel;
  logic unusedAlign;

  assign lkSet  = lkPc[ALIGN_W +: IDX_W];
  assign updSet = updPc[ALIGN_W +: IDX_W];
  assign lkTag  = lkPc[ADDR_W-1 -: TAG_W];
  assign updTag = updPc[ADDR_W-1 -: TAG_W];
  assign unusedAlign = ^{lkPc[ALIGN_W-1:0], updPc[ALIGN_W-1:0]};

  for (genvar w = 0; w < NEAR_WAYS; w++) begin : g_cmp
    assign lkNearMatch[w]  = nearValid[lkSet][w]  && (nearTag[lkSet][w]  == lkTag);
    assign updNearMatch[w] = nearValid[updSet][w] && (nearTag[updSet][w] == updTag);
  end

  assign lkFarMatch = farValid[lkSet]  && (farTag[lkSet]  == lkTag);
  assign updFarHit  = farValid[updSet] && (farTag[updSet] == updTag);
  assign updNearHit = |updNearMatch;

  // Lowest-numbered matching way wins; far way outranks all near ways.
  always_comb begin
    nearSel    = '0;
    updNearWay = '0;
    for (int w = NEAR_WAYS - 1; w >= 0; w--) begin
      if (lkNearMatch[w])  nearSel    = nearLow[lkSet][w];
      if (updNearMatch[w]) updNearWay = WAY_IDX_W'(w);
    end
  end

  always_comb begin
    lkHit    = lkFarMatch || (|lkNearMatch);
    lkTarget = '0;
    if (lkFarMatch)        lkTarget = farTgt[lkSet];
    else if (|lkNearMatch) lkTarget = {lkPc[ADDR_W-1:LOW_W], nearSel};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nearValid <= '{default: '0};
      farValid  <= '0;
    end else begin
      for (int w = 0; w < NEAR_WAYS; w++) begin
        if (strobe.killNear && updNearMatch[w]) nearValid[updSet][w] <= 1'b0;
        if (strobe.wrNear && strobe.nearWay == WAY_IDX_W'(w)) nearValid[updSet][w] <= 1'b1;
      end
      if (strobe.killFar) farValid[updSet] <= 1'b0;
      if (strobe.wrFar)   farValid[updSet] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < NEAR_WAYS; w++) begin
      if (strobe.wrNear && strobe.nearWay == WAY_IDX_W'(w)) begin
        nearTag[updSet][w] <= updTag;
        nearLow[updSet][w] <= updTarget[LOW_W-1:0];
      end
    end
    if (strobe.wrFar) begin
      farTag[updSet] <= updTag;
      farTgt[updSet] <= updTarget;
    end
  end
endmodule

// File: rtl/ctb_control.sv
module ctb_control
  import ctb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SETS      = 16,
  parameter int unsigned NEAR_WAYS = 2,
  parameter int unsigned LOW_W     = 16,
  parameter int unsigned ALIGN_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 updValid,
  input  logic [ADDR_W-1:0]    updPc,
  input  logic [ADDR_W-1:0]    updTarget,
  input  logic                 updTaken,
  input  logic                 updNearHit,
  input  logic [WAY_IDX_W-1:0] updNearWay,
  input  logic                 updFarHit,
  output ctbStrobe_t           strobe
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned RR_W  = (NEAR_WAYS > 1) ? $clog2(NEAR_WAYS) : 1;

  logic [RR_W-1:0]  rrPtr [SETS];
  logic [IDX_W-1:0] updSet;
  logic isFar, alloc;
  logic unusedCtl;

  assign updSet    = updPc[ALIGN_W +: IDX_W];
  assign isFar     = updPc[ADDR_W-1:LOW_W] != updTarget[ADDR_W-1:LOW_W];
  assign alloc     = updValid && updTaken && !isFar && !updNearHit;
  assign unusedCtl = ^{updPc[ALIGN_W-1:0], updPc[ADDR_W-1:ALIGN_W+IDX_W],
                       updTarget[LOW_W-1:0]};

  always_comb begin
    strobe = '0;
    if (updValid) begin
      if (!updTaken) begin
        strobe.killNear = updNearHit;
        strobe.killFar  = updFarHit;
      end else if (isFar) begin
        strobe.wrFar    = 1'b1;
        strobe.killNear = updNearHit;
      end else begin
        strobe.wrNear  = 1'b1;
        strobe.killFar = updFarHit;
        strobe.nearWay = updNearHit ? updNearWay : WAY_IDX_W'(rrPtr[updSet]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr <= '{default: '0};
    end else if (alloc) begin
      rrPtr[updSet] <= (rrPtr[updSet] == RR_W'(NEAR_WAYS - 1)) ? '0 : rrPtr[updSet] + 1'b1;
    end
  end
endmodule

// File: rtl/ctb_predictor.sv
module ctb_predictor
  import ctb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SETS      = 16,
  parameter int unsigned NEAR_WAYS = 2,
  parameter int unsigned LOW_W     = 16,
  parameter int unsigned ALIGN_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lkPc,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updTaken
);
  ctbStrobe_t           strobe;
  logic                 updNearHit;
  logic [WAY_IDX_W-1:0] updNearWay;
  logic                 updFarHit;

  ctb_control #(.ADDR_W(ADDR_W), .SETS(SETS), .NEAR_WAYS(NEAR_WAYS),
                .LOW_W(LOW_W), .ALIGN_W(ALIGN_W)) u_ctl (
    .clk(clk), .rst(rst), .updValid(updValid), .updPc(updPc),
    .updTarget(updTarget), .updTaken(updTaken), .updNearHit(updNearHit),
    .updNearWay(updNearWay), .updFarHit(updFarHit), .strobe(strobe)
  );

  ctb_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .NEAR_WAYS(NEAR_WAYS),
                 .LOW_W(LOW_W), .ALIGN_W(ALIGN_W)) u_dp (
    .clk(clk), .rst(rst), .lkPc(lkPc), .lkHit(lkHit), .lkTarget(lkTarget),
    .updPc(updPc), .updTarget(updTarget), .strobe(strobe),
    .updNearHit(updNearHit), .updNearWay(updNearWay), .updFarHit(updFarHit)
  );
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker
  import ctb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LOW_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lkHit,
  input logic [ADDR_W-1:0] lkTarget,
  input logic              updValid,
  input logic [ADDR_W-1:0] updPc,
  input logic [ADDR_W-1:0] updTarget,
  input logic              updTaken,
  input ctbStrobe_t        strobe,
  input logic              updNearHit,
  input logic              updFarHit
);
  logic farUpd;
  assign farUpd = updPc[ADDR_W-1:LOW_W] != updTarget[ADDR_W-1:LOW_W];

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !lkHit);  // R1
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lkHit |-> lkTarget == '0);  // R2
  AST_NEAR_CLASS: assert property (@(posedge clk) disable iff (rst)
    (updValid && updTaken && !farUpd) |-> (strobe.wrNear && !strobe.wrFar));  // R3
  AST_FAR_CLASS: assert property (@(posedge clk) disable iff (rst)
    (updValid && updTaken && farUpd) |-> (strobe.wrFar && !strobe.wrNear));  // R4
  AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (updValid && !updTaken) |-> (!strobe.wrNear && !strobe.wrFar));  // R8
  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    updValid |-> !(updNearHit && updFarHit));  // R9
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrNear, strobe.wrFar}));  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !updValid |-> (strobe == '0));  // R11
endmodule

bind ctb_predictor ctb_checker #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst(rst), .lkHit(lkHit), .lkTarget(lkTarget),
  .updValid(updValid), .updPc(updPc), .updTarget(updTarget),
  .updTaken(updTaken), .strobe(strobe), .updNearHit(updNearHit),
  .updFarHit(updFarHit)
);

// File: tb/ctb_predictor_tb.sv
module ctb_predictor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lkPc = '0;
  logic        lkHit;
  logic [31:0] lkTarget;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic        updTaken = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ctb_predictor u_dut (
    .clk(clk), .rst(rst), .lkPc(lkPc), .lkHit(lkHit), .lkTarget(lkTarget),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget), .updTaken(updTaken)
  );

  function automatic logic [31:0] mkPc(int tg, int s);
    return {26'(tg), 4'(s), 2'b00};
  endfunction
  function automatic logic [31:0] nearT(logic [31:0] pc, logic [15:0] lo);
    return {pc[31:16], lo};
  endfunction
  function automatic logic [31:0] farT(logic [31:0] pc, logic [15:0] lo);
    return {~pc[31:16], lo};
  endfunction
  function automatic int tgOf(int s, int k);
    return s * 8 + k + 32'h0001_2340;
  endfunction

  task automatic chk(input logic [31:0] pc, input logic expHit,
                     input logic [31:0] expTgt, input string req);
    lkPc = pc;
    #1;
    nChecks++;
    if (lkHit !== expHit || lkTarget !== expTgt) begin
      nFails++;
      $display("FAIL %s pc=%h: hit=%b tgt=%h, expected hit=%b tgt=%h",
               req, pc, lkHit, lkTarget, expHit, expTgt);
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTarget = tgt; updTaken = tk;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] pA, pB, pC, pD, pF, pX, pY, pZ, pW;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R2: empty after reset, misses read as zero
    for (int s = 0; s < 16; s++) begin
      chk(mkPc(tgOf(s, 0), s), 1'b0, 32'h0, "R1");
      chk(mkPc(tgOf(s, 7), s) | 32'h3, 1'b0, 32'h0, "R2");
    end

    // Train two near entries and one far entry in every set
    for (int s = 0; s < 16; s++) begin
      pA = mkPc(tgOf(s, 0), s); pB = mkPc(tgOf(s, 1), s); pF = mkPc(tgOf(s, 4), s);
      upd(pA, nearT(pA, 16'(16'h0100 + s)), 1'b1);
      upd(pB, nearT(pB, 16'(16'h0200 + s)), 1'b1);
      upd(pF, farT(pF, 16'(16'h0300 + s)), 1'b1);
    end
    for (int s = 0; s < 16; s++) begin
      pA = mkPc(tgOf(s, 0), s); pB = mkPc(tgOf(s, 1), s); pF = mkPc(tgOf(s, 4), s);
      chk(pA, 1'b1, nearT(pA, 16'(16'h0100 + s)), "R3");
      chk(pB, 1'b1, nearT(pB, 16'(16'h0200 + s)), "R9 near/far coexist");
      chk(pF, 1'b1, farT(pF, 16'(16'h0300 + s)), "R4");
      chk(pA | 32'h3, 1'b1, nearT(pA, 16'(16'h0100 + s)), "R5 align ignored");
      chk(mkPc(tgOf(s, 6), s), 1'b0, 32'h0, "R5 tag alias");
    end

    // R11: inputs with updValid low change nothing
    pA = mkPc(tgOf(13, 0), 13);
    @(negedge clk);
    updPc = pA; updTarget = farT(pA, 16'hDEAD); updTaken = 1'b0;
    @(negedge clk);
    chk(pA, 1'b1, nearT(pA, 16'h010D), "R11");

    // R6: in-place rewrite, pointer untouched
    pA = mkPc(tgOf(3, 0), 3); pB = mkPc(tgOf(3, 1), 3); pC = mkPc(tgOf(3, 2), 3);
    upd(pA, nearT(pA, 16'hBEEF), 1'b1);
    chk(pA, 1'b1, nearT(pA, 16'hBEEF), "R6 rewrite");
    chk(pB, 1'b1, nearT(pB, 16'h0203), "R6 neighbour kept");
    upd(pC, nearT(pC, 16'h4444), 1'b1);
    chk(pA, 1'b0, 32'h0, "R6 pointer not advanced");
    chk(pB, 1'b1, nearT(pB, 16'h0203), "R6");

    // R7: round-robin replacement
    pA = mkPc(tgOf(5, 0), 5); pB = mkPc(tgOf(5, 1), 5); pC = mkPc(tgOf(5, 2), 5);
    pD = mkPc(tgOf(5, 3), 5); pF = mkPc(tgOf(5, 4), 5);
    upd(pC, nearT(pC, 16'h5C5C), 1'b1);
    chk(pA, 1'b0, 32'h0, "R7 way0 evicted");
    chk(pB, 1'b1, nearT(pB, 16'h0205), "R7");
    chk(pC, 1'b1, nearT(pC, 16'h5C5C), "R7");
    upd(pD, nearT(pD, 16'h5D5D), 1'b1);
    chk(pB, 1'b0, 32'h0, "R7 way1 evicted");
    chk(pC, 1'b1, nearT(pC, 16'h5C5C), "R7");
    chk(pD, 1'b1, nearT(pD, 16'h5D5D), "R7");
    chk(pF, 1'b1, farT(pF, 16'h0305), "R7 far untouched");

    // R8: not-taken removal
    pA = mkPc(tgOf(7, 0), 7); pB = mkPc(tgOf(7, 1), 7); pF = mkPc(tgOf(7, 4), 7);
    upd(pA, nearT(pA, 16'h0107), 1'b0);
    chk(pA, 1'b0, 32'h0, "R8 near removed");
    chk(pB, 1'b1, nearT(pB, 16'h0207), "R8");
    chk(pF, 1'b1, farT(pF, 16'h0307), "R8");
    upd(pF, farT(pF, 16'h0307), 1'b0);
    chk(pF, 1'b0, 32'h0, "R8 far removed");
    chk(pB, 1'b1, nearT(pB, 16'h0207), "R8");

    // R9 / R10: class moves
    pA = mkPc(tgOf(9, 0), 9); pB = mkPc(tgOf(9, 1), 9); pF = mkPc(tgOf(9, 4), 9);
    upd(pA, farT(pA, 16'h9A9A), 1'b1);
    chk(pA, 1'b1, farT(pA, 16'h9A9A), "R9 near to far");
    chk(pF, 1'b0, 32'h0, "R10 far replaced");
    chk(pB, 1'b1, nearT(pB, 16'h0209), "R9");
    upd(pA, nearT(pA, 16'h7777), 1'b1);
    chk(pA, 1'b1, nearT(pA, 16'h7777), "R9 far to near");
    upd(pF, farT(pF, 16'h1111), 1'b1);
    chk(pA, 1'b1, nearT(pA, 16'h7777), "R9 single entry");
    chk(pF, 1'b1, farT(pF, 16'h1111), "R9");

    // R4 / R3: class boundary at bit 16 versus bit 15
    pX = mkPc(tgOf(11, 2), 11); pY = mkPc(tgOf(11, 3), 11);
    pZ = mkPc(tgOf(11, 5), 11); pW = mkPc(tgOf(11, 6), 11);
    upd(pX, pX ^ 32'h0001_0000, 1'b1);
    chk(pX, 1'b1, pX ^ 32'h0001_0000, "R4 bit16");
    upd(pY, farT(pY, 16'h2222), 1'b1);
    chk(pX, 1'b0, 32'h0, "R4 bit16 was far");
    chk(pY, 1'b1, farT(pY, 16'h2222), "R10");
    upd(pZ, pZ ^ 32'h0000_8000, 1'b1);
    upd(pW, farT(pW, 16'h3333), 1'b1);
    chk(pZ, 1'b1, pZ ^ 32'h0000_8000, "R3 bit15 near");
    chk(pW, 1'b1, farT(pW, 16'h3333), "R10");

    done = 1'b1;
    summary();
  end
endmodule